// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block sequences a block transfer between a register file and word-addressed memory for four kinds of operation: load-multiple, store-multiple, push and pop. A single-cycle start pulse presents an 8-bit register list, a base register number, a base address, the operation kind and an extra-register flag. The block then issues one memory beat per cycle. Each beat carries a word address, the register index being moved and a write strobe. When the beats are finished the block produces the updated base or stack-pointer value, the register it belongs to, and a one-cycle done pulse.

The register file and the memory sit outside the block. Only the beat and writeback ports connect to them. Push grows the stack toward lower addresses: the stack pointer is lowered by four bytes per register first, and the registers are then stored in ascending order from the new stack pointer. Pop reads in ascending order from the stack pointer and then raises it. A base address that is not word aligned raises a fault pulse, and no transfer starts.

Top module: `blk_xfer_seq`

## Requirements
- R1: Selected registers are moved in ascending register-number order. Consecutive beats use word addresses that rise by 4. Every beat address has its two low bits at zero.
- R2: With N selected registers (counting the extra register), the N beats occupy the cycles after start-sampling edges 1 to N. `done` is high for exactly one cycle, after edge 1+N. `busy` is high from the start edge until that done cycle ends.
- R3: op_kind 0 is load-multiple and 1 is store-multiple. Both start at the base address and ignore `incl_extra`. At done they write base+4N to register `base_idx`. `beat_write` is 0 for load beats and 1 for store beats.
- R4: In a load-multiple whose `base_idx` (below 8) is in the list, `base_we` stays low at done.
- R5: op_kind 2 is push. `incl_extra` adds register 14 to the list. Beats are writes starting at base-4N. At done, base-4N is written to register 13.
- R6: op_kind 3 is pop. `incl_extra` adds register 15 to the list. Beats are reads starting at the base. At done, base+4N is written to register 13, and `branch` pulses with `done` when register 15 was included.
- R7: A start whose base address has either of its two low bits set produces a one-cycle `fault` after the start edge. No beat, no done and no busy follow.
- R8: An empty effective list produces `done` one cycle after the start edge. There are no beats, `base_we` stays low and `branch` stays low.
- R9: A start pulse while `busy` is high is ignored. The running transfer's beats and results are unchanged, and no fault is raised.
- R10: After reset, `busy`, `beat_valid`, `done`, `base_we`, `branch` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled while idle |
| op_kind | input | 2 | 0 load-multiple, 1 store-multiple, 2 push, 3 pop |
| reg_list | input | 8 | Bitmap of registers 0..7 |
| incl_extra | input | 1 | Push adds register 14, pop adds register 15 |
| base_idx | input | 4 | Base register number for load/store-multiple |
| base_addr | input | 32 | Base address or stack pointer value |
| busy | output | 1 | Transfer in progress |
| beat_valid | output | 1 | A memory beat is presented this cycle |
| beat_write | output | 1 | Beat is a store (1) or a load (0) |
| beat_addr | output | 32 | Word address of the beat |
| beat_reg | output | 4 | Register index of the beat |
| done | output | 1 | One-cycle completion pulse |
| base_we | output | 1 | Write the updated base at done |
| base_we_idx | output | 4 | Register receiving the updated base |
| base_new | output | 32 | Updated base or stack pointer |
| branch | output | 1 | Pop restored the program counter |
| fault | output | 1 | One-cycle misaligned-base fault |

## Verification
Counting from the edge that samples `start` (edge 0), a fault is due right after edge 0. The k-th beat is due after edge k, and done with its writeback fields after edge 1+N. In the cycle after that, done must be low and busy must have fallen. The bench drives inputs on falling edges and samples every output on the falling edge after the edge being counted. For each run it walks exactly that schedule, so a beat or done that arrives one cycle early or late fails its check. It sweeps every 8-bit list under all four operations and both extra-flag values, with base numbers that fall inside and outside the list, and adds misaligned, empty-list and start-while-busy runs.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
    localparam int LIST_W     = 8;
    localparam int MASK_W     = 16;
    localparam int IDX_W      = $clog2(MASK_W);
    localparam int LIST_IDX_W = $clog2(LIST_W);
    localparam int AW         = 32;
    localparam int CNT_W      = $clog2(MASK_W + 1);
    localparam int SP_IDX     = 13;
    localparam int LINK_IDX   = 14;
    localparam int PC_IDX     = 15;
    localparam int WORD_BYTES = 4;

    typedef enum logic [1:0] {
        XOP_LOAD  = 2'd0,
        XOP_STORE = 2'd1,
        XOP_PUSH  = 2'd2,
        XOP_POP   = 2'd3
    } xop_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BEAT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    typedef struct packed {
        logic [AW-1:0]    new_base;
        logic             wb_en;
        logic [IDX_W-1:0] wb_idx;
        logic             pc_load;
    } finish_t;

    function automatic logic [CNT_W-1:0] count_bits(input logic [MASK_W-1:0] m);
        logic [CNT_W-1:0] c;
        c = '0;
        for (int i = 0; i < MASK_W; i++) c = c + CNT_W'(m[i]);
        return c;
    endfunction

    function automatic logic [MASK_W-1:0] drop_lowest(input logic [MASK_W-1:0] m);
        return m & (m - MASK_W'(1));
    endfunction
endpackage

// File: rtl/blk_xfer_pick.sv
module blk_xfer_pick
    import blk_xfer_pkg::*;
(
    input  logic [MASK_W-1:0] mask,
    output logic [IDX_W-1:0]  idx
);
    always_comb begin
        idx = '0;
        for (int i = MASK_W - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/blk_xfer_plan.sv
module blk_xfer_plan
    import blk_xfer_pkg::*;
(
    input  xop_e              op,
    input  logic [LIST_W-1:0] list,
    input  logic              extra,
    input  logic [IDX_W-1:0]  bidx,
    input  logic [AW-1:0]     base,
    output logic [MASK_W-1:0] mask,
    output logic [AW-1:0]     first_addr,
    output finish_t           fin,
    output logic              misaligned
);
    logic [CNT_W-1:0] n_regs;
    logic [AW-1:0]    span;
    logic             base_in_list;
    logic             stack_op;

    always_comb begin
        mask = '0;
        mask[LIST_W-1:0] = list;
        if (extra && op == XOP_PUSH) mask[LINK_IDX] = 1'b1;
        if (extra && op == XOP_POP)  mask[PC_IDX]   = 1'b1;
    end

    assign n_regs       = count_bits(mask);
    assign span         = AW'(n_regs) * AW'(WORD_BYTES);
    assign stack_op     = (op == XOP_PUSH) || (op == XOP_POP);
    assign base_in_list = (32'(bidx) < LIST_W) && list[bidx[LIST_IDX_W-1:0]];
    assign misaligned   = |base[1:0];

    always_comb begin
        first_addr   = (op == XOP_PUSH) ? base - span : base;
        fin.new_base = (op == XOP_PUSH) ? base - span : base + span;
        fin.wb_idx   = stack_op ? IDX_W'(SP_IDX) : bidx;
        fin.wb_en    = (n_regs != '0) && !(op == XOP_LOAD && base_in_list);
        fin.pc_load  = mask[PC_IDX];
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
    import blk_xfer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        op_kind,
    input  logic [LIST_W-1:0] reg_list,
    input  logic              incl_extra,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [AW-1:0]     base_addr,
    output logic              busy,
    output logic              beat_valid,
    output logic              beat_write,
    output logic [AW-1:0]     beat_addr,
    output logic [IDX_W-1:0]  beat_reg,
    output logic              done,
    output logic              base_we,
    output logic [IDX_W-1:0]  base_we_idx,
    output logic [AW-1:0]     base_new,
    output logic              branch,
    output logic              fault
);
    xop_e              op_in;
    logic [MASK_W-1:0] plan_mask;
    logic [AW-1:0]     plan_first;
    finish_t           plan_fin;
    logic              plan_misaligned;

    st_e               state;
    logic [MASK_W-1:0] mask_q;
    logic [AW-1:0]     addr_q;
    logic              write_q;
    finish_t           fin_q;
    logic              fault_q;
    logic [MASK_W-1:0] mask_rest;

    assign op_in = xop_e'(op_kind);

    blk_xfer_plan u_plan (
        .op         (op_in),
        .list       (reg_list),
        .extra      (incl_extra),
        .bidx       (base_idx),
        .base       (base_addr),
        .mask       (plan_mask),
        .first_addr (plan_first),
        .fin        (plan_fin),
        .misaligned (plan_misaligned)
    );

    blk_xfer_pick u_pick (
        .mask (mask_q),
        .idx  (beat_reg)
    );

    assign mask_rest = drop_lowest(mask_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            mask_q  <= '0;
            addr_q  <= '0;
            write_q <= 1'b0;
            fin_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (plan_misaligned) begin
                            fault_q <= 1'b1;
                        end else begin
                            state   <= ST_SETUP;
                            mask_q  <= plan_mask;
                            addr_q  <= plan_first;
                            write_q <= (op_in == XOP_STORE) || (op_in == XOP_PUSH);
                            fin_q   <= plan_fin;
                        end
                    end
                end
                ST_SETUP: begin
                    state <= (mask_q == '0) ? ST_DONE : ST_BEAT;
                end
                ST_BEAT: begin
                    mask_q <= mask_rest;
                    addr_q <= addr_q + AW'(WORD_BYTES);
                    if (mask_rest == '0) state <= ST_DONE;
                end
                ST_DONE: begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state != ST_IDLE);
    assign beat_valid  = (state == ST_BEAT);
    assign beat_write  = beat_valid && write_q;
    assign beat_addr   = addr_q;
    assign done        = (state == ST_DONE);
    assign base_we     = done && fin_q.wb_en;
    assign base_we_idx = fin_q.wb_idx;
    assign base_new    = fin_q.new_base;
    assign branch      = done && fin_q.pc_load;
    assign fault       = fault_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk
    import blk_xfer_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             beat_valid,
    input logic [AW-1:0]    beat_addr,
    input logic [IDX_W-1:0] beat_reg,
    input logic             done,
    input logic             base_we,
    input logic             branch,
    input logic             fault
);
    assert_beat_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_addr[1:0] == 2'b00));

    assert_addr_step_R1: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid)) |-> (beat_addr == $past(beat_addr) + AW'(WORD_BYTES)));

    assert_reg_ascending_R1: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid)) |-> (beat_reg > $past(beat_reg)));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_wb_with_done_R3: assert property (@(posedge clk) disable iff (rst)
        base_we |-> done);

    assert_branch_with_done_R6: assert property (@(posedge clk) disable iff (rst)
        branch |-> done);

    assert_fault_idle_R7: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!busy && !done));

    assert_fault_no_beat_R7: assert property (@(posedge clk) disable iff (rst)
        fault |=> !beat_valid);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .beat_valid (beat_valid),
    .beat_addr  (beat_addr),
    .beat_reg   (beat_reg),
    .done       (done),
    .base_we    (base_we),
    .branch     (branch),
    .fault      (fault)
);

// File: tb/blk_xfer_seq_bench.sv
`timescale 1ns/1ps
module blk_xfer_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [7:0]  reg_list = 8'd0;
    logic        incl_extra = 1'b0;
    logic [3:0]  base_idx = 4'd0;
    logic [31:0] base_addr = 32'd0;
    logic        busy, beat_valid, beat_write, done, base_we, branch, fault;
    logic [31:0] beat_addr, base_new;
    logic [3:0]  beat_reg, base_we_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    blk_xfer_seq u_blk_xfer_seq (
        .clk(clk), .rst(rst), .start(start), .op_kind(op_kind),
        .reg_list(reg_list), .incl_extra(incl_extra), .base_idx(base_idx),
        .base_addr(base_addr), .busy(busy), .beat_valid(beat_valid),
        .beat_write(beat_write), .beat_addr(beat_addr), .beat_reg(beat_reg),
        .done(done), .base_we(base_we), .base_we_idx(base_we_idx),
        .base_new(base_new), .branch(branch), .fault(fault)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transfer; poke=1 re-pulses start with other values during setup (R9).
    task automatic run(input int op, input logic [7:0] list, input bit extra,
                       input logic [3:0] bidx, input logic [31:0] base, input bit poke);
        logic [15:0] eff;
        int          n;
        int          regs[16];
        logic [31:0] addr;
        bit          wb;
        eff = {(op == 3) && extra, (op == 2) && extra, 6'd0, list};
        n = 0;
        for (int i = 0; i < 16; i++) if (eff[i]) begin regs[n] = i; n++; end
        addr = (op == 2) ? base - 32'(4 * n) : base;
        wb = (n != 0) && !(op == 0 && bidx < 8 && list[bidx[2:0]]);

        @(negedge clk);
        op_kind = 2'(op); reg_list = list; incl_extra = extra;
        base_idx = bidx; base_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, 1, "R2 busy in setup");
        chk(beat_valid, 0, "R2 no beat in setup");
        chk(fault, 0, "R7 no fault when aligned");
        if (poke) begin
            op_kind = 2'(3 - op); reg_list = ~list; incl_extra = ~extra;
            base_addr = base + 32'd2; start = 1'b1;
        end
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(beat_valid, 1, "R2 beat valid");
            chk(32'(beat_reg), 32'(regs[k]), "R1 beat register order");
            chk(beat_addr, addr + 32'(4 * k), "R1 beat address");
            chk(beat_write, (op == 1 || op == 2) ? 1 : 0, "R3 beat direction");
            chk(done, 0, "R2 no early done");
            if (poke) chk(fault, 0, "R9 start ignored while busy");
        end
        @(negedge clk);
        start = 1'b0;
        chk(done, 1, n == 0 ? "R8 empty list done" : "R2 done after 1+N");
        chk(beat_valid, 0, "R2 no beat at done");
        chk(base_we, wb, op == 0 ? "R4 load writeback decision" : "R3 writeback enable");
        if (wb) begin
            if (op >= 2) begin
                chk(32'(base_we_idx), 13, "R5 stack pointer index");
                chk(base_new, (op == 2) ? base - 32'(4 * n) : base + 32'(4 * n),
                    op == 2 ? "R5 push new sp" : "R6 pop new sp");
            end else begin
                chk(32'(base_we_idx), 32'(bidx), "R3 base index");
                chk(base_new, base + 32'(4 * n), "R3 base plus 4N");
            end
        end
        chk(branch, (op == 3 && extra) ? 1 : 0, "R6 branch on pc restore");
        @(negedge clk);
        chk(done, 0, "R2 done single cycle");
        chk(busy, 0, "R2 busy released");
        chk(fault, 0, "R9 no fault from ignored start");
    endtask

    task automatic run_fault(input int op, input logic [31:0] base);
        @(negedge clk);
        op_kind = 2'(op); reg_list = 8'hA5; incl_extra = 1'b1;
        base_idx = 4'd9; base_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(fault, 1, "R7 fault after start edge");
        chk(busy, 0, "R7 no busy on fault");
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(fault, 0, "R7 fault single cycle");
            chk(beat_valid | done | busy, 0, "R7 no transfer after fault");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({busy, beat_valid, done, base_we, branch, fault}, 0, "R10 outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        chk({busy, beat_valid, done, base_we, branch, fault}, 0, "R10 outputs after reset");

        for (int l = 0; l < 256; l++) begin
            for (int op = 0; op < 4; op++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [7:0] lv;
                    lv = 8'(l);
                    run(op, lv, e[0], {lv[4], lv[2:0]}, 32'h0001_0000 + 32'(l * 16),
                        (l % 7) == 3);
                end
            end
        end
        run(0, 8'h00, 1'b1, 4'd2, 32'h200, 1'b0);
        run(0, 8'h04, 1'b0, 4'd2, 32'h200, 1'b0);
        run(1, 8'h04, 1'b0, 4'd2, 32'h200, 1'b0);
        run(2, 8'hFF, 1'b1, 4'd0, 32'h2000_0100, 1'b1);
        run(3, 8'hFF, 1'b1, 4'd0, 32'h2000_00DC, 1'b1);
        run(3, 8'h00, 1'b1, 4'd0, 32'h40, 1'b0);
        run(2, 8'h00, 1'b0, 4'd0, 32'h40, 1'b0);
        run_fault(0, 32'h101);
        run_fault(1, 32'h102);
        run_fault(2, 32'h103);
        run_fault(3, 32'h106);
        run(1, 8'h81, 1'b0, 4'd9, 32'h300, 1'b0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule